// File: doc/BRIEF.md
# Peripheral Register Bank with Set/Clear Interrupt Mask

This block is the common register front end that sits between a 32-bit peripheral bus and the core logic of a peripheral. It holds a configuration word for the core and turns single bus writes into one-cycle command strobes. It collects event flags that the core raises and clears. It also decides whether those flags should produce an interrupt request.

The interrupt mask is never written directly. One word sets mask bits and another word clears them, so software changes any subset of mask bits with a single store and no read-modify-write. The mask is read back through its own read-only word. Each status flag is ANDed with its mask bit and the results are OR-reduced into one request line. By default that line is registered.

The bus is a zero-wait APB-style interface. A write takes effect on the access-phase edge, and read data is driven combinationally during a read transfer. All accesses are treated as whole 32-bit words.

Top module: `pbank_regs`

## Requirements
- R1: The two lowest address bits are ignored. A read or write at any byte offset within a word reaches that aligned word (for example 0x07 selects the word at 0x04).
- R2: Bits that are not implemented read as 0 and are not stored. With the default widths, mode bits 31:16 and mask/status bits 31:8 read 0.
- R3: A write to the command word (offset 0x00) drives `cmd_pulse` with the written 1-bits for exactly the one cycle after the write edge. Bits written as 0 stay low, and the command word reads as 0.
- R4: The configuration word (offset 0x04) is readable and writable, appears on `mode_cfg`, holds its value until written again, and is 0 after reset.
- R5: Each 1-bit written to the mask-set word (offset 0x14) sets the matching mask bit. Each 0-bit leaves its mask bit unchanged.
- R6: Each 1-bit written to the mask-clear word (offset 0x18) clears the matching mask bit. Each 0-bit leaves its mask bit unchanged.
- R7: The mask-view word (offset 0x1C) returns the current mask. The mask-set word, the mask-clear word, the command word and every unmapped offset read as 0.
- R8: A pulse on bit i of `evt_set` sets status bit i, and a pulse on bit i of `evt_clr` clears it. If both pulses arrive in the same cycle, the bit ends up set. Status reads at offset 0x10, and bus writes to that offset have no effect.
- R9: `irq` equals the OR over all bits of (status AND mask), delayed by one clock.
- R10: After reset, configuration, mask, status, `cmd_pulse` and `irq` are all 0.
- R11: Registers change only on an access-phase write (`psel`, `penable` and `pwrite` all high). A setup-phase cycle alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read transfer, 0 otherwise |
| evt_set | input | NSRC (8) | Per-bit status set pulses from the core |
| evt_clr | input | NSRC (8) | Per-bit status clear pulses from the core |
| cmd_pulse | output | CMD_W (8) | One-cycle command strobes |
| mode_cfg | output | MODE_W (16) | Configuration word to the core |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted mask bit shows up at the mask-view word on the next read. It also shows up on `irq` one clock after the matching status bit is set, so sweeping every mask value against shifting status patterns exposes any stuck, swapped or cross-coupled mask bit within two cycles. A wrong set/clear priority or a lost status edge changes the status readback and `irq` within one and two cycles respectively. A command register that fails to clear itself appears as `cmd_pulse` staying high past its single cycle.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
   localparam int BUS_W = 32;
   // word indices (byte offset / 4)
   localparam int IDX_CMD  = 0;
   localparam int IDX_MODE = 1;
   localparam int IDX_STAT = 4;
   localparam int IDX_MSET = 5;
   localparam int IDX_MCLR = 6;
   localparam int IDX_MVIEW = 7;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CMD,
      SEL_MODE,
      SEL_STAT,
      SEL_MSET,
      SEL_MCLR,
      SEL_MVIEW
   } reg_sel_e;

   function automatic reg_sel_e word_to_sel(input logic [2:0] low, input logic high_zero);
      reg_sel_e s;
      s = SEL_NONE;
      if (high_zero) begin
         case (int'(low))
            IDX_CMD:   s = SEL_CMD;
            IDX_MODE:  s = SEL_MODE;
            IDX_STAT:  s = SEL_STAT;
            IDX_MSET:  s = SEL_MSET;
            IDX_MCLR:  s = SEL_MCLR;
            IDX_MVIEW: s = SEL_MVIEW;
            default:   s = SEL_NONE;
         endcase
      end
      return s;
   endfunction
endpackage

// File: rtl/pbank_decode.sv
module pbank_decode
   import pbank_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   output reg_sel_e          sel,
   output logic              wr_en,
   output logic              rd_en
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] widx;
   logic             unused_lsb;

   assign widx       = paddr[ADDR_W-1:2];
   assign unused_lsb = ^paddr[1:0];

   generate
      if (IDX_W > 3) begin : g_wide
         assign sel = word_to_sel(widx[2:0], widx[IDX_W-1:3] == '0);
      end else begin : g_narrow
         assign sel = word_to_sel(widx[2:0], 1'b1);
      end
   endgenerate

   assign wr_en = psel & penable & pwrite;
   assign rd_en = psel & ~pwrite;
endmodule

// File: rtl/pbank_mask.sv
module pbank_mask #(
   parameter int NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_we,
   input  logic            clr_we,
   input  logic [NSRC-1:0] wbits,
   output logic [NSRC-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (set_we)
         mask_q <= mask_q | wbits;
      else if (clr_we)
         mask_q <= mask_q & ~wbits;
   end
endmodule

// File: rtl/pbank_status.sv
module pbank_status #(
   parameter int NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt_set,
   input  logic [NSRC-1:0] evt_clr,
   output logic [NSRC-1:0] status_q
);
   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            status_q[i] <= 1'b0;
         else if (evt_set[i])
            status_q[i] <= 1'b1;
         else if (evt_clr[i])
            status_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/pbank_regs.sv
module pbank_regs
   import pbank_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int CMD_W   = 8,
   parameter int MODE_W  = 16,
   parameter int NSRC    = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   input  logic [NSRC-1:0]   evt_set,
   input  logic [NSRC-1:0]   evt_clr,
   output logic [CMD_W-1:0]  cmd_pulse,
   output logic [MODE_W-1:0] mode_cfg,
   output logic              irq
);
   generate
      if (ADDR_W < 6 || ADDR_W > 16) begin : g_bad_addr
         $error("pbank_regs: ADDR_W out of range");
      end
      if (CMD_W < 1 || CMD_W > BUS_W) begin : g_bad_cmd
         $error("pbank_regs: CMD_W out of range");
      end
      if (MODE_W < 1 || MODE_W > BUS_W) begin : g_bad_mode
         $error("pbank_regs: MODE_W out of range");
      end
      if (NSRC < 1 || NSRC > BUS_W) begin : g_bad_nsrc
         $error("pbank_regs: NSRC out of range");
      end
   endgenerate

   reg_sel_e         sel;
   logic             wr_en;
   logic             rd_en;
   logic [NSRC-1:0]  mask_q;
   logic [NSRC-1:0]  status_q;
   logic [MODE_W-1:0] mode_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [31:0]      rd_word;
   logic             irq_next;
   logic             unused_wdata;

   assign unused_wdata = ^pwdata;

   pbank_decode #(.ADDR_W(ADDR_W)) i_decode (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .sel     (sel),
      .wr_en   (wr_en),
      .rd_en   (rd_en)
   );

   pbank_mask #(.NSRC(NSRC)) i_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_en && sel == SEL_MSET),
      .clr_we (wr_en && sel == SEL_MCLR),
      .wbits  (pwdata[NSRC-1:0]),
      .mask_q (mask_q)
   );

   pbank_status #(.NSRC(NSRC)) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_set  (evt_set),
      .evt_clr  (evt_clr),
      .status_q (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         cmd_q  <= '0;
      end else begin
         if (wr_en && sel == SEL_MODE)
            mode_q <= pwdata[MODE_W-1:0];
         cmd_q <= (wr_en && sel == SEL_CMD) ? pwdata[CMD_W-1:0] : '0;
      end
   end

   always_comb begin
      rd_word = '0;
      case (sel)
         SEL_MODE:  rd_word[MODE_W-1:0] = mode_q;
         SEL_STAT:  rd_word[NSRC-1:0]   = status_q;
         SEL_MVIEW: rd_word[NSRC-1:0]   = mask_q;
         default:   rd_word = '0;
      endcase
   end

   assign prdata    = rd_en ? rd_word : '0;
   assign cmd_pulse = cmd_q;
   assign mode_cfg  = mode_q;
   assign irq_next  = |(status_q & mask_q);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= irq_next;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_next;
      end
   endgenerate
endmodule

// File: rtl/pbank_chk.sv
module pbank_chk #(
   parameter int ADDR_W  = 8,
   parameter int CMD_W   = 8,
   parameter int MODE_W  = 16,
   parameter int NSRC    = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       pwdata,
   input logic [NSRC-1:0]   evt_set,
   input logic [CMD_W-1:0]  cmd_pulse,
   input logic [MODE_W-1:0] mode_cfg,
   input logic              irq,
   input logic [NSRC-1:0]   mask_q,
   input logic [NSRC-1:0]   status_q
);
   logic              acc_wr;
   logic [ADDR_W-3:0] widx;
   logic              unused_chk;

   assign acc_wr     = psel && penable && pwrite;
   assign widx       = paddr[ADDR_W-1:2];
   assign unused_chk = ^{paddr[1:0], pwdata};

   // R3: no command write, no strobe next cycle
   p_cmd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_wr && widx == 0) |=> cmd_pulse == '0);

   // R4 / R11: configuration holds without an access-phase write to it
   p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_wr && widx == 1) |=> $stable(mode_cfg));

   p_mode_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && widx == 1) |=> mode_cfg == $past(pwdata[MODE_W-1:0]));

   // R5: set word turns on the written ones
   p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && widx == 5) |=> (mask_q & $past(pwdata[NSRC-1:0])) == $past(pwdata[NSRC-1:0]));

   // R6: clear word turns off the written ones
   p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && widx == 6) |=> (mask_q & $past(pwdata[NSRC-1:0])) == '0);

   // R8: set pulses always land
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_set) |=> (status_q & $past(evt_set)) == $past(evt_set));

   // R9: request follows masked status by one cycle
   generate
      if (IRQ_REG) begin : g_irq_chk
         p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq == |($past(status_q) & $past(mask_q)));
      end
   endgenerate
endmodule

bind pbank_regs pbank_chk #(
   .ADDR_W (ADDR_W),
   .CMD_W  (CMD_W),
   .MODE_W (MODE_W),
   .NSRC   (NSRC),
   .IRQ_REG(IRQ_REG)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .psel     (psel),
   .penable  (penable),
   .pwrite   (pwrite),
   .paddr    (paddr),
   .pwdata   (pwdata),
   .evt_set  (evt_set),
   .cmd_pulse(cmd_pulse),
   .mode_cfg (mode_cfg),
   .irq      (irq),
   .mask_q   (mask_q),
   .status_q (status_q)
);

// File: tb/test_pbank_regs.sv
module test_pbank_regs;
   localparam int ADDR_W = 8;
   localparam int CMD_W  = 8;
   localparam int MODE_W = 16;
   localparam int NSRC   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [ADDR_W-1:0] paddr = '0;
   logic [31:0]       pwdata = '0;
   logic [31:0]       prdata;
   logic [NSRC-1:0]   evt_set = '0, evt_clr = '0;
   logic [CMD_W-1:0]  cmd_pulse;
   logic [MODE_W-1:0] mode_cfg;
   logic              irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pbank_regs i_pbank_regs (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .evt_set(evt_set),
      .evt_clr(evt_clr), .cmd_pulse(cmd_pulse), .mode_cfg(mode_cfg), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // starts and ends just after a falling edge
   task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(posedge clk); @(negedge clk);
      penable = 1'b1;
      @(posedge clk); @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(posedge clk); @(negedge clk);
      penable = 1'b1;
      #1 d = prdata;
      @(posedge clk); @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic evt(input logic [NSRC-1:0] s, input logic [NSRC-1:0] c);
      evt_set = s; evt_clr = c;
      @(posedge clk); @(negedge clk);
      evt_set = '0; evt_clr = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [7:0]  model_mask;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 irq", {31'b0, irq}, 0);
      chk("R10 cmd", {24'b0, cmd_pulse}, 0);
      bus_rd(8'h04, rd); chk("R10 mode", rd, 0);
      bus_rd(8'h1C, rd); chk("R10 mask", rd, 0);
      bus_rd(8'h10, rd); chk("R10 status", rd, 0);

      // R4 configuration word
      bus_wr(8'h04, 32'h1234_A5C3);
      chk("R4 mode_cfg", {16'b0, mode_cfg}, 32'hA5C3);
      bus_rd(8'h04, rd); chk("R4 readback", rd, 32'hA5C3);

      // R1 low address bits ignored
      bus_wr(8'h07, 32'h0000_5A5A);
      bus_rd(8'h06, rd); chk("R1 sub-word", rd, 32'h5A5A);
      bus_rd(8'h1D, rd); chk("R1 mask alias", rd, 0);

      // R11 setup phase alone writes nothing
      psel = 1'b1; pwrite = 1'b1; paddr = 8'h04; pwdata = 32'hFFFF_FFFF;
      @(posedge clk); @(negedge clk);
      psel = 1'b0; pwrite = 1'b0;
      chk("R11 setup only", {16'b0, mode_cfg}, 32'h5A5A);

      // R2 unimplemented bits
      bus_wr(8'h04, 32'hFFFF_FFFF);
      bus_rd(8'h04, rd); chk("R2 mode width", rd, 32'h0000_FFFF);
      bus_wr(8'h14, 32'hFFFF_FFFF);
      bus_rd(8'h1C, rd); chk("R2 mask width", rd, 32'h0000_00FF);
      bus_wr(8'h18, 32'hFFFF_FFFF);

      // R3 command strobes
      bus_wr(8'h00, 32'hFFFF_FF81);
      chk("R3 strobe", {24'b0, cmd_pulse}, 32'h81);
      @(negedge clk);
      chk("R3 one cycle", {24'b0, cmd_pulse}, 0);
      bus_wr(8'h00, 32'h0);
      chk("R3 zero write", {24'b0, cmd_pulse}, 0);
      bus_rd(8'h00, rd); chk("R3 reads zero", rd, 0);

      // R7 write-only and unmapped offsets
      bus_rd(8'h14, rd); chk("R7 set word", rd, 0);
      bus_rd(8'h18, rd); chk("R7 clear word", rd, 0);
      bus_rd(8'h08, rd); chk("R7 unmapped 08", rd, 0);
      bus_rd(8'h20, rd); chk("R7 unmapped 20", rd, 0);
      bus_rd(8'hFC, rd); chk("R7 unmapped FC", rd, 0);

      // R5 set one bit at a time, zeros leave others alone
      model_mask = 8'h00;
      for (int b = 0; b < NSRC; b++) begin
         bus_wr(8'h14, 32'(1) << b);
         model_mask = model_mask | (8'(1) << b);
         bus_rd(8'h1C, rd); chk("R5 set bit", rd, {24'b0, model_mask});
      end
      bus_wr(8'h14, 32'h0);
      bus_rd(8'h1C, rd); chk("R5 zero write", rd, 32'hFF);

      // R6 clear one bit at a time
      for (int b = 0; b < NSRC; b++) begin
         bus_wr(8'h18, 32'(1) << b);
         model_mask = model_mask & ~(8'(1) << b);
         bus_rd(8'h1C, rd); chk("R6 clear bit", rd, {24'b0, model_mask});
      end
      bus_wr(8'h14, 32'h3C);
      bus_wr(8'h18, 32'h0);
      bus_rd(8'h1C, rd); chk("R6 zero write", rd, 32'h3C);
      bus_wr(8'h18, 32'hFF);

      // R8 status set / clear / priority / write ignored
      evt(8'hA5, 8'h00);
      bus_rd(8'h10, rd); chk("R8 set", rd, 32'hA5);
      evt(8'h00, 8'h05);
      bus_rd(8'h10, rd); chk("R8 clear", rd, 32'hA0);
      evt(8'h40, 8'hC0);
      bus_rd(8'h10, rd); chk("R8 set wins", rd, 32'h60);
      bus_wr(8'h10, 32'h0000_00FF);
      bus_rd(8'h10, rd); chk("R8 write ignored", rd, 32'h60);
      chk("R9 masked off", {31'b0, irq}, 0);

      // R9 one-cycle latency on the request
      bus_wr(8'h14, 32'h20);
      chk("R9 before latency", {31'b0, irq}, 0);
      @(negedge clk);
      chk("R9 after latency", {31'b0, irq}, 1);
      bus_wr(8'h18, 32'h20);
      @(negedge clk);
      chk("R9 drops", {31'b0, irq}, 0);

      // R9 sweep of every mask against varying status
      for (int m = 0; m < 256; m++) begin
         logic [7:0] s;
         s = 8'((m * 29 + 7) ^ (m >> 3));
         bus_wr(8'h18, 32'hFF);
         bus_wr(8'h14, 32'(m));
         evt(8'h00, 8'hFF);
         evt(s, 8'h00);
         @(negedge clk);
         chk("R9 sweep", {31'b0, irq}, {31'b0, |(s & 8'(m))});
         if (m % 16 == 0) begin
            bus_rd(8'h1C, rd); chk("R7 sweep mask", rd, 32'(m));
            bus_rd(8'h10, rd); chk("R8 sweep status", rd, {24'b0, s});
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule